// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings a one-bank, 32-bit wide asynchronous DRAM array (four byte lanes, each with its own column strobe) out of power-up and then keeps its contents alive. After reset it stays silent for a programmable pause. It then runs a burst of initialisation refresh cycles and raises a done flag. From then on it schedules one refresh per programmable interval. Every refresh puts the column strobes low before the row strobe, so the DRAM's internal row counter supplies the address and no address lines are needed.

The sequencer shares the strobe lines with a separate access controller through a request and grant handshake. It raises a bus request while any refresh is owed. Once granted, it runs the owed refreshes back to back. It lowers the request only after the row-strobe precharge of the last refresh in the burst has elapsed. Refreshes that come due while the grant is withheld are counted, up to a fixed maximum. All timing limits are parameters in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, busReq is 0, initDone is 0, and rasN, every casN lane and weN are 1.
- R2: busReq first goes high exactly PAUSE_CYCLES clock cycles after reset release. No strobe moves before that.
- R3: After the pause, exactly INIT_REFRESHES refresh cycles run. initDone rises when the precharge of the last one ends, and it then stays high until reset.
- R4: In every refresh, all casN lanes fall together, and rasN falls exactly CAS_LEAD_CYC cycles later.
- R5: casN rises exactly CAS_HOLD_CYC cycles after rasN falls, and rasN stays low for exactly RAS_LOW_CYC cycles.
- R6: Between two refreshes, rasN is high for at least RAS_PRE_CYC + CAS_LEAD_CYC cycles. weN is always high.
- R7: After initialisation, with the grant given at once, successive refreshes start exactly REFRESH_INTERVAL cycles apart.
- R8: A refresh starts only in a cycle where busGrant was sampled high.
- R9: If the grant is withheld while k refreshes come due, the burst that follows the grant holds min(k, MAX_PENDING) refreshes.
- R10: busReq falls exactly RAS_PRE_CYC cycles after the last rasN rise of a burst, and not while a refresh is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Strobe lines handed to this block by the access controller |
| busReq | output | 1 | Request for the strobe lines |
| rasN | output | 1 | Row strobe, active low |
| casN | output | CAS_LANES | Column strobes, one per byte lane, active low |
| weN | output | 1 | Write enable, active low, held inactive |
| initDone | output | 1 | Power-up sequence complete, normal access allowed |

## Verification
The assertions assume the access controller behaves as follows. It gives busGrant only while busReq is high. Once it gives the grant, it holds it until busReq falls. It does not grant again until it sees a new request. The bench's grant model follows these rules under every stimulus. It draws a random grant latency for each request. It also blocks the grant for a chosen number of refresh intervals, so that pending refreshes build up below the saturation point, at it, and above it. It never pulls the grant away in the middle of a burst.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CAS_LEAD,
    PH_RAS_HOLD,
    PH_RAS_REST,
    PH_PRECHARGE
  } phase_e;

  typedef struct packed {
    logic takeOne;   // a refresh cycle starts, consume one owed refresh
    logic burstEnd;  // precharge finished and nothing more is owed
  } seq_cmd_t;

endpackage

// File: rtl/refresh_timers.sv
module refresh_timers
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYCLES     = 25000,
  parameter int INIT_REFRESHES   = 8,
  parameter int REFRESH_INTERVAL = 1900,
  parameter int MAX_PENDING      = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  seq_cmd_t cmd,
  output logic     pauseDone,
  output logic     pendingNz,
  output logic     initDone
);

  localparam int PAUSE_W  = $clog2(PAUSE_CYCLES + 1);
  localparam int IVL_W    = $clog2(REFRESH_INTERVAL + 1);
  localparam int PEND_TOP = (MAX_PENDING > INIT_REFRESHES) ? MAX_PENDING : INIT_REFRESHES;
  localparam int PEND_W   = $clog2(PEND_TOP + 1);
  localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYCLES - 1);
  localparam logic [IVL_W-1:0]   IVL_LAST   = IVL_W'(REFRESH_INTERVAL - 1);
  localparam logic [PEND_W-1:0]  PEND_CAP   = PEND_W'(MAX_PENDING);
  localparam logic [PEND_W-1:0]  PEND_INIT  = PEND_W'(INIT_REFRESHES);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [IVL_W-1:0]   ivlCnt;
  logic [PEND_W-1:0]  pendCnt;
  logic [PEND_W-1:0]  afterTake;
  logic [PEND_W-1:0]  pendNext;
  logic               pauseEnd;
  logic               tick;

  assign pauseEnd = !pauseDone && (pauseCnt == PAUSE_LAST);
  assign tick     = initDone && (ivlCnt == IVL_LAST);

  // power-up pause
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseCnt  <= '0;
      pauseDone <= 1'b0;
    end else if (!pauseDone) begin
      if (pauseEnd) pauseDone <= 1'b1;
      else          pauseCnt  <= pauseCnt + 1'b1;
    end
  end

  // refresh interval, free running once initialisation is over
  always_ff @(posedge clk) begin
    if (!rstN)         ivlCnt <= '0;
    else if (initDone) ivlCnt <= tick ? '0 : ivlCnt + 1'b1;
  end

  // owed refreshes, saturating
  always_comb begin
    afterTake = pendCnt - PEND_W'(cmd.takeOne);
    pendNext  = (tick && (afterTake < PEND_CAP)) ? afterTake + 1'b1 : afterTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         pendCnt <= '0;
    else if (pauseEnd) pendCnt <= PEND_INIT;
    else               pendCnt <= pendNext;
  end

  assign pendingNz = (pendCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)                           initDone <= 1'b0;
    else if (cmd.burstEnd && pauseDone)  initDone <= 1'b1;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == PEND_CAP && tick && !cmd.takeOne) |=> (pendCnt == PEND_CAP));

  assert_take_needs_owed_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.takeOne |-> pendingNz);

  assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int CAS_LEAD_CYC = 2,
  parameter int CAS_HOLD_CYC = 2,
  parameter int RAS_LOW_CYC  = 8,
  parameter int RAS_PRE_CYC  = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busGrant,
  input  logic     pendingNz,
  input  logic     pauseDone,
  output seq_cmd_t cmd,
  output logic     busReq,
  output logic     rasLine,
  output logic     casLine
);

  localparam int TMR_W = $clog2(CAS_LEAD_CYC + RAS_LOW_CYC + RAS_PRE_CYC + 1);
  localparam logic [TMR_W-1:0] LEAD_LAST = TMR_W'(CAS_LEAD_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(CAS_HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] REST_LAST = TMR_W'(RAS_LOW_CYC - CAS_HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] PRE_LAST  = TMR_W'(RAS_PRE_CYC - 1);

  phase_e           phase;
  phase_e           phaseNext;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] tmrLoad;
  logic             advance;
  logic             startOk;

  assign startOk = pendingNz && busGrant;

  always_comb begin
    advance   = 1'b0;
    phaseNext = phase;
    tmrLoad   = '0;
    cmd       = '0;
    unique case (phase)
      PH_IDLE: if (startOk) begin
        advance     = 1'b1;
        phaseNext   = PH_CAS_LEAD;
        tmrLoad     = LEAD_LAST;
        cmd.takeOne = 1'b1;
      end
      PH_CAS_LEAD: if (tmr == '0) begin
        advance   = 1'b1;
        phaseNext = PH_RAS_HOLD;
        tmrLoad   = HOLD_LAST;
      end
      PH_RAS_HOLD: if (tmr == '0) begin
        advance   = 1'b1;
        phaseNext = PH_RAS_REST;
        tmrLoad   = REST_LAST;
      end
      PH_RAS_REST: if (tmr == '0) begin
        advance   = 1'b1;
        phaseNext = PH_PRECHARGE;
        tmrLoad   = PRE_LAST;
      end
      PH_PRECHARGE: if (tmr == '0) begin
        advance = 1'b1;
        if (startOk) begin
          phaseNext   = PH_CAS_LEAD;
          tmrLoad     = LEAD_LAST;
          cmd.takeOne = 1'b1;
        end else begin
          phaseNext    = PH_IDLE;
          cmd.burstEnd = !pendingNz;
        end
      end
      default: begin
        advance   = 1'b1;
        phaseNext = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      tmr   <= '0;
    end else if (advance) begin
      phase <= phaseNext;
      tmr   <= tmrLoad;
    end else if (phase != PH_IDLE) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign rasLine = !(phase == PH_RAS_HOLD || phase == PH_RAS_REST);
  assign casLine = !(phase == PH_CAS_LEAD || phase == PH_RAS_HOLD);
  assign busReq  = (phase != PH_IDLE) || pendingNz;

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasLine) |-> !$past(casLine));

  assert_cas_after_ras_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casLine) |-> !rasLine);

  assert_start_needs_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casLine) |-> $past(busGrant));

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pauseDone |-> (!busReq && rasLine && casLine));

  assert_release_after_precharge_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> ($past(phase) == PH_PRECHARGE));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int CAS_LANES        = 4,
  parameter int PAUSE_CYCLES     = 25000,
  parameter int INIT_REFRESHES   = 8,
  parameter int REFRESH_INTERVAL = 1900,
  parameter int MAX_PENDING      = 8,
  parameter int CAS_LEAD_CYC     = 2,
  parameter int CAS_HOLD_CYC     = 2,
  parameter int RAS_LOW_CYC      = 8,
  parameter int RAS_PRE_CYC      = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busGrant,
  output logic                 busReq,
  output logic                 rasN,
  output logic [CAS_LANES-1:0] casN,
  output logic                 weN,
  output logic                 initDone
);

  seq_cmd_t seqCmd;
  logic     pauseDone;
  logic     pendingNz;
  logic     casLine;

  refresh_timers #(
    .PAUSE_CYCLES    (PAUSE_CYCLES),
    .INIT_REFRESHES  (INIT_REFRESHES),
    .REFRESH_INTERVAL(REFRESH_INTERVAL),
    .MAX_PENDING     (MAX_PENDING)
  ) u_timers (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (seqCmd),
    .pauseDone(pauseDone),
    .pendingNz(pendingNz),
    .initDone (initDone)
  );

  refresh_seq #(
    .CAS_LEAD_CYC(CAS_LEAD_CYC),
    .CAS_HOLD_CYC(CAS_HOLD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .RAS_PRE_CYC (RAS_PRE_CYC)
  ) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .pendingNz(pendingNz),
    .pauseDone(pauseDone),
    .cmd      (seqCmd),
    .busReq   (busReq),
    .rasLine  (rasN),
    .casLine  (casLine)
  );

  for (genvar lane = 0; lane < CAS_LANES; lane++) begin : g_cas
    assign casN[lane] = casLine;
  end

  // refresh only, never a write
  assign weN = 1'b1;

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;

  localparam int PAUSE = 400;
  localparam int INITN = 8;
  localparam int IVL   = 300;
  localparam int MAXP  = 8;
  localparam int LEAD  = 2;
  localparam int HOLD  = 2;
  localparam int RLOW  = 8;
  localparam int RPRE  = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busGrant = 1'b0;
  logic       busReq, rasN, weN, initDone;
  logic [3:0] casN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  bit blockGrant = 1'b0;
  int grantDelay = 2;
  int waitCnt = 0;

  int rasFalls = 0;
  int lastCasFall = -100000;
  int lastRasFall = -100000;
  int lastRasRise = -100000;
  int firstReqCyc = -1;
  bit initSeen = 1'b0;
  bit ivlMode = 1'b0;
  int ivlPrev = -1;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .CAS_LANES(4), .PAUSE_CYCLES(PAUSE), .INIT_REFRESHES(INITN),
    .REFRESH_INTERVAL(IVL), .MAX_PENDING(MAXP), .CAS_LEAD_CYC(LEAD),
    .CAS_HOLD_CYC(HOLD), .RAS_LOW_CYC(RLOW), .RAS_PRE_CYC(RPRE)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .busReq(busReq),
    .rasN(rasN), .casN(casN), .weN(weN), .initDone(initDone)
  );

  function automatic int expBurst(int k);
    return (k > MAXP) ? MAXP : k;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial forever @(posedge clk) if (rstN) cyc++;

  // access controller model: grant after a delay, hold until request drops
  initial forever @(negedge clk) begin
    if (!busReq) begin
      busGrant <= 1'b0;
      waitCnt = 0;
    end else if (!busGrant && !blockGrant) begin
      if (waitCnt >= grantDelay) busGrant <= 1'b1;
      else waitCnt++;
    end
  end

  // strobe monitor
  initial begin
    logic       pRas = 1'b1;
    logic [3:0] pCas = 4'hF;
    logic       pReq = 1'b0;
    forever @(negedge clk) begin
      if (rstN) begin
        if (pCas == 4'hF && casN != 4'hF) begin
          check(casN == 4'h0, "R4 lanes fall together", casN, 0);
          check(rasN == 1'b1, "R4 ras high at cas fall", rasN, 1);
          check(busGrant == 1'b1, "R8 grant before start", busGrant, 1);
          lastCasFall = cyc;
        end
        if (pRas && !rasN) begin
          check(cyc - lastCasFall == LEAD, "R4 cas lead", cyc - lastCasFall, LEAD);
          check(cyc - lastRasRise >= RPRE + LEAD, "R6 ras high gap", cyc - lastRasRise, RPRE + LEAD);
          check(weN == 1'b1, "R6 we high", weN, 1);
          if (ivlMode) begin
            if (ivlPrev >= 0) check(cyc - ivlPrev == IVL, "R7 refresh spacing", cyc - ivlPrev, IVL);
            ivlPrev = cyc;
          end
          rasFalls++;
          lastRasFall = cyc;
        end
        if (pCas == 4'h0 && casN == 4'hF)
          check(!rasN && (cyc - lastRasFall == HOLD), "R5 cas hold", cyc - lastRasFall, HOLD);
        if (!pRas && rasN) begin
          check(cyc - lastRasFall == RLOW, "R5 ras low width", cyc - lastRasFall, RLOW);
          lastRasRise = cyc;
        end
        if (pReq && !busReq)
          check(rasN && (cyc - lastRasRise == RPRE), "R10 release after precharge", cyc - lastRasRise, RPRE);
        if (!pReq && busReq && firstReqCyc < 0) firstReqCyc = cyc;
        if (initDone && !initSeen) begin
          initSeen = 1'b1;
          check(rasFalls == INITN, "R3 init refresh count", rasFalls, INITN);
          check(busReq == 1'b0, "R3 bus released at init done", busReq, 0);
        end
        if (initSeen) check(initDone == 1'b1, "R3 init flag sticky", initDone, 1);
      end
      pRas = rasN;
      pCas = casN;
      pReq = busReq;
    end
  end

  task automatic waitNeg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic satTest(int k);
    int base;
    while (busReq) @(negedge clk);
    blockGrant = 1'b1;
    while (!busReq) @(negedge clk);
    waitNeg((k - 1) * IVL + IVL / 2);
    base = rasFalls;
    check(rasFalls == base && busGrant == 1'b0, "R8 no refresh while blocked", busGrant, 0);
    blockGrant = 1'b0;
    @(negedge clk);
    while (busReq) @(negedge clk);
    check(rasFalls - base == expBurst(k), "R9 burst length", rasFalls - base, expBurst(k));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    waitNeg(5);
    check(busReq == 1'b0, "R1 reset busReq", busReq, 0);
    check(rasN == 1'b1, "R1 reset rasN", rasN, 1);
    check(casN == 4'hF, "R1 reset casN", casN, 4'hF);
    check(weN == 1'b1, "R1 reset weN", weN, 1);
    check(initDone == 1'b0, "R1 reset initDone", initDone, 0);
    rstN = 1'b1;
    waitNeg(2);
    check(busReq == 1'b0 && rasN == 1'b1, "R1 idle after reset", busReq, 0);

    while (!initDone) @(negedge clk);
    check(firstReqCyc == PAUSE, "R2 pause length", firstReqCyc, PAUSE);

    // R7: immediate grant, constant spacing
    grantDelay = 0;
    begin
      int b = rasFalls;
      while (rasFalls == b) @(negedge clk);
    end
    ivlPrev = -1;
    ivlMode = 1'b1;
    begin
      int b = rasFalls;
      while (rasFalls < b + 5) @(negedge clk);
    end
    ivlMode = 1'b0;

    // R9: directed corners then random counts
    satTest(1);
    satTest(MAXP);
    satTest(MAXP + 1);
    satTest(12);
    for (int t = 0; t < 3; t++) satTest(int'($urandom_range(1, 12)));

    // random grant latency
    for (int t = 0; t < 12; t++) begin
      int b = rasFalls;
      grantDelay = int'($urandom_range(0, 6));
      while (rasFalls == b) @(negedge clk);
    end
    while (busReq) @(negedge clk);
    waitNeg(4);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    summary();
  end

endmodule